// File: doc/BRIEF.md
# 8-bit Arithmetic Unit with Status Flags

This block is the datapath arithmetic unit of a small accumulator-style processor. It takes two 8-bit operands and a 3-bit operation code. Its 8-bit result is combinational. It supports addition, subtraction, register copy (operand A plus zero), one-bit logical shifts in either direction, compare, and run-time address formation (an address field plus a register offset).

A three-bit status register holds zero, negative and overflow. It is loaded on the rising clock edge when the flag-update enable is high and the operation is one that defines flags. A compare only sets the flags: its result-write qualifier stays low, so the register file keeps its contents. Address formation never touches the flags, so a memory access between a compare and a branch leaves the branch condition intact.

Top module: `alu8_core`

## Requirements
- R1: Op code 0 (add) gives result = (A + B) mod 256 with res_wr high.
- R2: Op code 1 (subtract) gives result = (A - B) mod 256 with res_wr high.
- R3: Op code 2 (copy) gives result = A whatever B is, with res_wr high. When flags are loaded for it, overflow is 0 and zero and negative come from the result.
- R4: Op code 3 shifts A left by one and fills bit 0 with 0. Op code 4 shifts A right by one and fills bit 7 with 0. Both drive res_wr high.
- R5: On a flag load for op code 3 the overflow flag takes A[7]. For op code 4 it takes A[0].
- R6: The flags output is bit 0 zero, bit 1 negative, bit 2 overflow. On add and subtract, zero means the 8-bit result is 0, negative copies result bit 7, and overflow flags a two's-complement signed overflow.
- R7: Op code 5 (compare) outputs A - B on result, holds res_wr low, and loads the flags exactly as subtract would.
- R8: Op code 6 (address) outputs (A + B) mod 256 with res_wr low. It leaves the flags unchanged even when flag_en is high.
- R9: When rst_n is low at a rising clock edge, the flags become 000.
- R10: Flags change only at a rising edge where flag_en is high and the op code is 0 to 5. Otherwise they hold.
- R11: Op code 7 is reserved: result 0, res_wr low, flags held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset of the flags |
| op | input | 3 | Operation code (see R1 to R11) |
| opnd_a | input | 8 | Operand A (destination register value or address field) |
| opnd_b | input | 8 | Operand B (source register value or offset) |
| flag_en | input | 1 | Allows the flags to load at the next rising edge |
| result | output | 8 | Combinational result |
| res_wr | output | 1 | High when the result is meant to be written to a register |
| flags | output | 3 | Status flags: bit 0 zero, bit 1 negative, bit 2 overflow |

## Verification
The result and res_wr are combinational. They are due in the same cycle the inputs are applied, so the bench drives on the falling edge and samples them 1 ns later, before the next rising edge. The flags pass through one register and are due one rising edge after the cycle that requested them. The bench's behavioural model commits its expected flags only at that edge and compares them at the following falling edge. A flag load and the next operation's result are therefore never sampled in the same instant.

// File: rtl/alu8_pkg.sv
// Package: shared operation codes and flag layout for the 8-bit arithmetic unit.
// Assumes: op codes are fixed by the instruction decoder that drives the unit.
package alu8_pkg;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_PASS = 3'd2,
        OP_SHL  = 3'd3,
        OP_SHR  = 3'd4,
        OP_CMP  = 3'd5,
        OP_ADDR = 3'd6,
        OP_RSVD = 3'd7
    } alu_op_e;

    // bit 0 zero, bit 1 negative, bit 2 overflow
    typedef struct packed {
        logic ovf;
        logic neg;
        logic zero;
    } alu_flags_t;

endpackage

// File: rtl/alu8_arith.sv
// Module: add/subtract stage with two's-complement overflow detection.
// Assumes: subtraction is done as A + ~B + 1, so a single carry chain serves both.
module alu8_arith #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] sum,
    output logic         ovf
);

    logic [W-1:0] b_eff;

    // Invert B for subtraction and add with carry-in.
    always_comb begin
        b_eff = sub ? ~b : b;
        sum   = a + b_eff + {{(W-1){1'b0}}, sub};
        ovf   = (a[W-1] == b_eff[W-1]) && (sum[W-1] != a[W-1]);
    end

endmodule

// File: rtl/alu8_shift.sv
// Module: one-bit logical shifter in either direction with the bit pushed out exposed.
// Assumes: vacated positions are filled with zero.
module alu8_shift #(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic         right,
    output logic [W-1:0] shifted,
    output logic         spill
);

    // Select the shift direction and the bit that falls off the end.
    always_comb begin
        if (right) begin
            shifted = {1'b0, a[W-1:1]};
            spill   = a[0];
        end else begin
            shifted = {a[W-2:0], 1'b0};
            spill   = a[W-1];
        end
    end

endmodule

// File: rtl/alu8_flags.sv
// Module: status flag register with synchronous active-low reset and load enable.
// Assumes: the caller has already folded the op-code qualification into upd.
module alu8_flags
    import alu8_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  alu_flags_t nxt,
    output alu_flags_t q
);

    // Load the new flags on enable, clear them on reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (upd) q <= nxt;
    end

    // R9
    flags_rst_chk: assert property (@(posedge clk) !rst_n |=> (q == '0));

    // R10
    flags_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(q));

endmodule

// File: rtl/alu8_core.sv
// Module: 8-bit arithmetic unit top. It decodes the op code, steers the operands to the
// adder or the shifter, picks the result and builds the next flag value.
// Assumes: the result is consumed in the same cycle and the flags one edge later.
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [2:0]   op,
    input  logic [W-1:0] opnd_a,
    input  logic [W-1:0] opnd_b,
    input  logic         flag_en,
    output logic [W-1:0] result,
    output logic         res_wr,
    output logic [2:0]   flags
);

    alu_op_e      op_e;
    logic [W-1:0] add_b;
    logic         add_sub;
    logic [W-1:0] add_sum;
    logic         add_ovf;
    logic [W-1:0] sh_val;
    logic         sh_spill;
    logic         defines_flags;
    alu_flags_t   nxt_flags;
    alu_flags_t   flags_q;

    assign op_e = alu_op_e'(op);

    // Route operand B to the adder: zero for copy, otherwise B.
    always_comb begin
        add_b   = (op_e == OP_PASS) ? '0 : opnd_b;
        add_sub = (op_e == OP_SUB) || (op_e == OP_CMP);
    end

    alu8_arith #(.W(W)) u_arith (
        .a   (opnd_a),
        .b   (add_b),
        .sub (add_sub),
        .sum (add_sum),
        .ovf (add_ovf)
    );

    alu8_shift #(.W(W)) u_shift (
        .a       (opnd_a),
        .right   (op_e == OP_SHR),
        .shifted (sh_val),
        .spill   (sh_spill)
    );

    // Select the result, the write qualifier and the next flag value.
    always_comb begin
        result        = '0;
        res_wr        = 1'b0;
        defines_flags = 1'b0;
        nxt_flags     = '0;
        case (op_e)
            OP_ADD, OP_SUB, OP_PASS: begin
                result        = add_sum;
                res_wr        = 1'b1;
                defines_flags = 1'b1;
                nxt_flags.ovf = add_ovf;
            end
            OP_CMP: begin
                result        = add_sum;
                defines_flags = 1'b1;
                nxt_flags.ovf = add_ovf;
            end
            OP_SHL, OP_SHR: begin
                result        = sh_val;
                res_wr        = 1'b1;
                defines_flags = 1'b1;
                nxt_flags.ovf = sh_spill;
            end
            OP_ADDR: begin
                result = add_sum;
            end
            default: begin
                result = '0;
            end
        endcase
        nxt_flags.zero = (result == '0);
        nxt_flags.neg  = result[W-1];
    end

    alu8_flags u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (flag_en && defines_flags),
        .nxt   (nxt_flags),
        .q     (flags_q)
    );

    assign flags = flags_q;

    // R2
    sub_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd1) |-> (W'(result + opnd_b) == opnd_a));

    // R5
    shl_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op == 3'd3) |=> (flags[2] == $past(opnd_a[W-1])));

    // R5
    shr_spill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op == 3'd4) |=> (flags[2] == $past(opnd_a[0])));

    // R8
    addr_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd6) |=> $stable(flags));

    // R7
    cmp_nowr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (op == 3'd5) |-> (!res_wr && W'(result + opnd_b) == opnd_a));

endmodule

// File: tb/test_alu8_core.sv
`timescale 1ns/1ps
// Bench: behavioural model of the arithmetic unit, compared every cycle.
module test_alu8_core;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] op = 3'd0;
    logic [7:0] opnd_a = 8'd0;
    logic [7:0] opnd_b = 8'd0;
    logic       flag_en = 1'b0;
    logic [7:0] result;
    logic       res_wr;
    logic [2:0] flags;

    int checks = 0;
    int fails  = 0;
    logic [2:0] exp_flags = 3'b000;

    always #2.5 clk = ~clk;

    alu8_core i_alu8_core (
        .clk(clk), .rst_n(rst_n), .op(op), .opnd_a(opnd_a), .opnd_b(opnd_b),
        .flag_en(flag_en), .result(result), .res_wr(res_wr), .flags(flags)
    );

    function automatic string tag(input int o);
        case (o)
            0: return "R1";
            1: return "R2";
            2: return "R3";
            3, 4: return "R4";
            5: return "R7";
            6: return "R8";
            default: return "R11";
        endcase
    endfunction

    function automatic int sgn(input int v);
        return (v >= 128) ? v - 256 : v;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    // One cycle: check the flags from the last edge, apply inputs, check the result, update the model.
    task automatic step(input int o, input int a, input int b, input bit en, input bit rst);
        int r, sv, ovf;
        bit wr, defd;
        @(negedge clk);
        check((rst_n == 1'b0) ? "R9" : "R10", flags, exp_flags);
        rst_n = !rst; op = o[2:0]; opnd_a = a[7:0]; opnd_b = b[7:0]; flag_en = en;
        #1;
        r = 0; ovf = 0; wr = 1; defd = 1;
        case (o)
            0: begin r = (a + b) % 256; sv = sgn(a) + sgn(b); ovf = (sv > 127 || sv < -128); end
            1, 5: begin r = (a - b + 256) % 256; sv = sgn(a) - sgn(b); ovf = (sv > 127 || sv < -128);
                  wr = (o == 1); end
            2: r = a;
            3: begin r = (a * 2) % 256; ovf = a / 128; end
            4: begin r = a / 2; ovf = a % 2; end
            6: begin r = (a + b) % 256; wr = 0; defd = 0; end
            default: begin r = 0; wr = 0; defd = 0; end
        endcase
        if (!rst) begin
            check(tag(o), result, r);
            check(tag(o), res_wr, wr);
        end
        if (rst) exp_flags = 3'b000;
        else if (en && defd) exp_flags = {ovf[0], (r >= 128), (r == 0)};
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        step(0, 0, 0, 1, 1);
        step(0, 0, 0, 1, 1);
        // R1 add with carry-out wrap and R6 zero flag
        step(0, 8'hFF, 8'h01, 1, 0);
        // R6 signed overflow on add: 0x7F + 1
        step(0, 8'h7F, 8'h01, 1, 0);
        // R2 subtract, R6 overflow: 0x80 - 1
        step(1, 8'h80, 8'h01, 1, 0);
        // R3 copy ignores B, overflow cleared
        step(2, 8'h90, 8'h5A, 1, 0);
        step(2, 8'h00, 8'hFF, 1, 0);
        // R4/R5 shifts with spill
        step(3, 8'h81, 0, 1, 0);
        step(4, 8'h81, 0, 1, 0);
        step(4, 8'h02, 0, 1, 0);
        // R7 compare: equal, then less
        step(5, 8'h33, 8'h33, 1, 0);
        step(5, 8'h10, 8'h20, 1, 0);
        // R8 address with flag_en high leaves flags
        step(6, 8'hF0, 8'h20, 1, 0);
        // R10 enable low holds flags
        step(0, 8'h00, 8'h00, 0, 0);
        // R11 reserved code
        step(7, 8'h12, 8'h34, 1, 0);
        step(3, 8'h40, 0, 1, 0);
        // R9 reset mid-run clears flags
        step(1, 8'h00, 8'h01, 1, 0);
        step(0, 0, 0, 0, 1);
        step(0, 0, 0, 0, 0);
        for (int i = 0; i < 400; i++)
            step($urandom % 8, $urandom % 256, $urandom % 256, ($urandom % 4) != 0, 0);
        step(0, 0, 0, 0, 0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule